// File: doc/BRIEF.md
# SDRAM Mode Register Write Decoder

This block watches CPU accesses for two small address windows, one for each SDRAM chip-select area. When a 16-bit write lands inside a window, the block issues a mode-register-set command to that area's SDRAM. Chip select, RAS, CAS and write-enable are all driven low together for one clock. The SDRAM address pins carry the write's byte offset within the window, so software chooses the mode value through the address it writes to. The write data never reaches the block and plays no part in the command.

The second window starts 0x1000 above the first. The window that matches selects which chip select goes low. Every SDRAM address pin above the offset field is held at zero during the command. Before issuing, the block waits until the memory side reports the bus is free. After the command it counts a fixed mode-set delay, then pulses a done signal back to the CPU.

Any other access that hits a window gets an immediate done and causes no SDRAM activity. This covers reads, byte writes and longword writes. Offsets outside the supported mode set are still issued, and they raise an error flag together with done.

Top module: `sdram_mrs_decoder`

## Requirements
- R1: After reset, all chip selects, RAS, CAS and write-enable are high (inactive), the SDRAM address bus is zero, and done and error are low.
- R2: A word write (size code 01, write high) to 0xFFF84000 + X drives sd_cs_n_o[0], RAS, CAS and write-enable low together for exactly one clock, with X on sd_addr_o[11:0].
- R3: A word write to 0xFFF85000 + X does the same on sd_cs_n_o[1]. Exactly one chip select is ever low, and only during a command.
- R4: While a command is driven, sd_addr_o bits 12 and up are zero.
- R5: An accepted request waits while sd_rdy_i is low. The command appears in the clock after the clock edge at which sd_rdy_i is seen high.
- R6: cpu_done_o is high for exactly one clock, three clocks after the command clock. That is two mode-set delay clocks and then the done clock.
- R7: A window hit that is not a word write (read, size 00 byte or size 10 longword) raises cpu_done_o in the clock after acceptance, with no command and no error.
- R8: An access outside both windows produces no command and no done.
- R9: mode_err_o is high with cpu_done_o when the mode value is not one of 0x020, 0x030, 0x220 or 0x230. Those values mean: burst length 1 in bits 2:0, sequential wrap in bit 3, CAS latency 2 or 3 in bits 6:4, and burst or single write in bit 9. The command is issued anyway.
- R10: Requests made while an earlier request is still in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Access strobe, one clock |
| cpu_wr_i | input | 1 | 1 = write, 0 = read |
| cpu_size_i | input | 2 | Access size: 00 byte, 01 word, 10 longword |
| cpu_addr_i | input | 32 | CPU byte address |
| sd_rdy_i | input | 1 | SDRAM bus free for a command |
| sd_cs_n_o | output | 2 | Per-area chip select, active low |
| sd_ras_n_o | output | 1 | RAS, active low |
| sd_cas_n_o | output | 1 | CAS, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_addr_o | output | 15 | SDRAM address pins |
| cpu_done_o | output | 1 | Access complete pulse |
| mode_err_o | output | 1 | Unsupported mode value, valid with done |

## Verification
Some properties are checked on every cycle by the assertions:
- The command lasts a single clock.
- At most one chip select is low, and none is low outside a command.
- The upper address bits are zero while a command is driven.
- A pending request holds while ready is low.
- Done is a one-clock pulse, and the error flag never appears without it.

Other behaviour only the bench scenarios can show, by comparing each clock against a behavioural model:
- The mode value comes from the address offset.
- Each window selects its own area.
- The exact clock in which done follows the command.
- The early done with no command for non-word or read hits.
- Silence for addresses outside the windows.
- Which offsets raise the error flag.

// File: rtl/sdram_mrs_pkg.sv
package sdram_mrs_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CMD,
    ST_DLY,
    ST_DONE
  } mrs_state_e;

endpackage

// File: rtl/sdram_mrs_win_dec.sv
module sdram_mrs_win_dec #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned OFS_W      = 12,
  parameter int unsigned NUM_AREAS  = 2,
  parameter logic [31:0] WIN_BASE   = 32'hFFF8_4000,
  parameter logic [31:0] WIN_STRIDE = 32'h0000_1000,
  localparam int unsigned AREA_W    = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 hit_o,
  output logic [AREA_W-1:0]    area_o,
  output logic [OFS_W-1:0]     ofs_o
);

  logic [NUM_AREAS-1:0] hit_vec;

  for (genvar a = 0; a < NUM_AREAS; a++) begin : g_win
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(WIN_BASE + a * WIN_STRIDE);
    assign hit_vec[a] = (addr_i[ADDR_W-1:OFS_W] == BASE_A[ADDR_W-1:OFS_W]);
  end

  always_comb begin
    area_o = '0;
    for (int i = 0; i < NUM_AREAS; i++) begin
      if (hit_vec[i]) area_o = AREA_W'(i);
    end
  end

  assign hit_o = |hit_vec;
  assign ofs_o = addr_i[OFS_W-1:0];

endmodule

// File: rtl/sdram_mrs_mode_chk.sv
module sdram_mrs_mode_chk #(
  parameter int unsigned OFS_W = 12
) (
  input  logic [OFS_W-1:0] mode_i,
  output logic             bad_o
);

  // Bit 4 picks CL2/CL3, bit 9 picks burst/single write; all else fixed.
  localparam logic [OFS_W-1:0] DONT_CARE = OFS_W'(12'h210);
  localparam logic [OFS_W-1:0] FIXED_VAL = OFS_W'(12'h020);

  assign bad_o = ((mode_i & ~DONT_CARE) != FIXED_VAL);

endmodule

// File: rtl/sdram_mrs_seq.sv
module sdram_mrs_seq
  import sdram_mrs_pkg::*;
#(
  parameter int unsigned OFS_W     = 12,
  parameter int unsigned AREA_W    = 1,
  parameter int unsigned MSET_DLY  = 2,
  localparam int unsigned CNT_W    = (MSET_DLY > 1) ? $clog2(MSET_DLY) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              hit_i,
  input  logic              word_wr_i,
  input  logic [OFS_W-1:0]  mode_i,
  input  logic [AREA_W-1:0] area_i,
  input  logic              bad_i,
  input  logic              sd_rdy_i,
  output logic              issue_o,
  output logic [OFS_W-1:0]  mode_o,
  output logic [AREA_W-1:0] area_o,
  output logic              done_o,
  output logic              err_o
);

  mrs_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [OFS_W-1:0]  mode_q;
  logic [AREA_W-1:0] area_q;
  logic              bad_q;
  logic              accept;

  assign accept = (state_q == ST_IDLE) && req_i && hit_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = word_wr_i ? ST_WAIT : ST_DONE;
      ST_WAIT: if (sd_rdy_i) state_d = ST_CMD;
      ST_CMD:  state_d = ST_DLY;
      ST_DLY:  if (cnt_q == CNT_W'(MSET_DLY - 1)) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= '0;
      area_q  <= '0;
      bad_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DLY) cnt_q <= cnt_q + 1'b1;
      else                   cnt_q <= '0;
      if (accept) begin
        mode_q <= mode_i;
        area_q <= area_i;
        bad_q  <= word_wr_i & bad_i;   // skipped accesses never flag
      end
    end
  end

  assign issue_o = (state_q == ST_WAIT) && sd_rdy_i;
  assign mode_o  = mode_q;
  assign area_o  = area_q;
  assign done_o  = (state_q == ST_DONE);
  assign err_o   = done_o && bad_q;

  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !sd_rdy_i) |=> (state_q == ST_WAIT)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R9
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DLY && req_i) |=> (state_q inside {ST_DLY, ST_DONE})); // R10

endmodule

// File: rtl/sdram_mrs_cmd_out.sv
module sdram_mrs_cmd_out #(
  parameter int unsigned OFS_W     = 12,
  parameter int unsigned SDA_W     = 15,
  parameter int unsigned NUM_AREAS = 2,
  parameter int unsigned AREA_W    = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 issue_i,
  input  logic [OFS_W-1:0]     mode_i,
  input  logic [AREA_W-1:0]    area_i,
  output logic [NUM_AREAS-1:0] cs_n_o,
  output logic                 ras_n_o,
  output logic                 cas_n_o,
  output logic                 we_n_o,
  output logic [SDA_W-1:0]     addr_o
);

  logic [NUM_AREAS-1:0] cs_sel;

  for (genvar a = 0; a < NUM_AREAS; a++) begin : g_cs
    assign cs_sel[a] = (area_i == AREA_W'(a));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_o  <= '1;
      ras_n_o <= 1'b1;
      cas_n_o <= 1'b1;
      we_n_o  <= 1'b1;
      addr_o  <= '0;
    end else begin
      cs_n_o  <= issue_i ? ~cs_sel : '1;
      ras_n_o <= ~issue_i;
      cas_n_o <= ~issue_i;
      we_n_o  <= ~issue_i;
      addr_o  <= issue_i ? SDA_W'(mode_i) : '0;   // zero-extends above offset
    end
  end

  AST_CMD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |=> ras_n_o); // R2
  AST_ONE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o)); // R3
  AST_CS_ONLY_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_n_o |-> (cs_n_o == '1 && addr_o == '0)); // R1

  if (SDA_W > OFS_W) begin : g_upper_chk
    AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ras_n_o |-> (addr_o[SDA_W-1:OFS_W] == '0)); // R4
  end

endmodule

// File: rtl/sdram_mrs_decoder.sv
module sdram_mrs_decoder
  import sdram_mrs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned OFS_W      = 12,
  parameter int unsigned SDA_W      = 15,
  parameter int unsigned NUM_AREAS  = 2,
  parameter logic [31:0] WIN_BASE   = 32'hFFF8_4000,
  parameter logic [31:0] WIN_STRIDE = 32'h0000_1000,
  parameter int unsigned MSET_DLY   = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cpu_req_i,
  input  logic                 cpu_wr_i,
  input  logic [1:0]           cpu_size_i,
  input  logic [ADDR_W-1:0]    cpu_addr_i,
  input  logic                 sd_rdy_i,
  output logic [NUM_AREAS-1:0] sd_cs_n_o,
  output logic                 sd_ras_n_o,
  output logic                 sd_cas_n_o,
  output logic                 sd_we_n_o,
  output logic [SDA_W-1:0]     sd_addr_o,
  output logic                 cpu_done_o,
  output logic                 mode_err_o
);

  localparam int unsigned AREA_W = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1;

  logic              hit;
  logic [AREA_W-1:0] dec_area, cmd_area;
  logic [OFS_W-1:0]  dec_ofs, cmd_mode;
  logic              mode_bad;
  logic              word_wr;
  logic              issue;

  assign word_wr = cpu_wr_i && (cpu_size_i == SZ_WORD);

  sdram_mrs_win_dec #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .NUM_AREAS(NUM_AREAS),
    .WIN_BASE(WIN_BASE), .WIN_STRIDE(WIN_STRIDE)
  ) u_win_dec (
    .addr_i (cpu_addr_i),
    .hit_o  (hit),
    .area_o (dec_area),
    .ofs_o  (dec_ofs)
  );

  sdram_mrs_mode_chk #(.OFS_W(OFS_W)) u_mode_chk (
    .mode_i (dec_ofs),
    .bad_o  (mode_bad)
  );

  sdram_mrs_seq #(
    .OFS_W(OFS_W), .AREA_W(AREA_W), .MSET_DLY(MSET_DLY)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (cpu_req_i),
    .hit_i     (hit),
    .word_wr_i (word_wr),
    .mode_i    (dec_ofs),
    .area_i    (dec_area),
    .bad_i     (mode_bad),
    .sd_rdy_i  (sd_rdy_i),
    .issue_o   (issue),
    .mode_o    (cmd_mode),
    .area_o    (cmd_area),
    .done_o    (cpu_done_o),
    .err_o     (mode_err_o)
  );

  sdram_mrs_cmd_out #(
    .OFS_W(OFS_W), .SDA_W(SDA_W), .NUM_AREAS(NUM_AREAS), .AREA_W(AREA_W)
  ) u_cmd_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (issue),
    .mode_i  (cmd_mode),
    .area_i  (cmd_area),
    .cs_n_o  (sd_cs_n_o),
    .ras_n_o (sd_ras_n_o),
    .cas_n_o (sd_cas_n_o),
    .we_n_o  (sd_we_n_o),
    .addr_o  (sd_addr_o)
  );

  AST_CMD_LINES_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_ras_n_o == sd_cas_n_o) && (sd_cas_n_o == sd_we_n_o)
    && ((sd_cs_n_o == '1) == sd_ras_n_o)); // R2
  AST_NO_DONE_IN_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_ras_n_o |-> !cpu_done_o); // R6

endmodule

// File: tb/sdram_mrs_decoder_tb.sv
module sdram_mrs_decoder_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_req_i = 1'b0;
  logic        cpu_wr_i = 1'b0;
  logic [1:0]  cpu_size_i = 2'b00;
  logic [31:0] cpu_addr_i = '0;
  logic        sd_rdy_i = 1'b1;
  logic [1:0]  sd_cs_n_o;
  logic        sd_ras_n_o, sd_cas_n_o, sd_we_n_o;
  logic [14:0] sd_addr_o;
  logic        cpu_done_o, mode_err_o;

  always #5 clk_i = ~clk_i;

  sdram_mrs_decoder dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req_i), .cpu_wr_i(cpu_wr_i), .cpu_size_i(cpu_size_i),
    .cpu_addr_i(cpu_addr_i), .sd_rdy_i(sd_rdy_i),
    .sd_cs_n_o(sd_cs_n_o), .sd_ras_n_o(sd_ras_n_o), .sd_cas_n_o(sd_cas_n_o),
    .sd_we_n_o(sd_we_n_o), .sd_addr_o(sd_addr_o),
    .cpu_done_o(cpu_done_o), .mode_err_o(mode_err_o)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R1";
  bit    chk_en  = 1'b0;
  bit    finished = 1'b0;

  // Behavioural reference: phase 0 idle, 1 wait, 2 cmd, 3..4 delay, 5 done, 10 early done
  int          m_ph = 0;
  int          m_area = 0;
  logic [11:0] m_val = '0;
  bit          m_bad = 1'b0;
  int          cmd_cycles = 0;
  int          done_cycles = 0;

  always @(posedge clk_i) begin
    chk_en <= 1'b1;
    if (!rst_ni) begin
      m_ph = 0;
    end else begin
      case (m_ph)
        0: if (cpu_req_i && (cpu_addr_i[31:12] == 20'hFFF84 || cpu_addr_i[31:12] == 20'hFFF85)) begin
             if (cpu_wr_i && cpu_size_i == 2'b01) begin
               m_ph   = 1;
               m_area = (cpu_addr_i[31:12] == 20'hFFF85) ? 1 : 0;
               m_val  = cpu_addr_i[11:0];
               m_bad  = !(m_val inside {12'h020, 12'h030, 12'h220, 12'h230});
             end else begin
               m_ph = 10;
             end
           end
        1:  if (sd_rdy_i) m_ph = 2;
        2:  m_ph = 3;
        3:  m_ph = 4;
        4:  m_ph = 5;
        default: m_ph = 0;
      endcase
    end
  end

  task automatic check(input string tag, input bit ok, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (chk_en && !finished) begin
      logic        e_cmd;
      logic [1:0]  e_cs;
      logic [14:0] e_addr;
      logic        e_done, e_err;
      e_cmd  = (m_ph == 2);
      e_cs   = e_cmd ? ~(2'b01 << m_area) : 2'b11;
      e_addr = e_cmd ? {3'b000, m_val} : 15'h0;
      e_done = (m_ph == 5) || (m_ph == 10);
      e_err  = (m_ph == 5) && m_bad;
      check({cur_req, " cs"}, sd_cs_n_o == e_cs, sd_cs_n_o, e_cs);
      check({cur_req, " cmd"}, {sd_ras_n_o, sd_cas_n_o, sd_we_n_o} == {3{~e_cmd}},
            {sd_ras_n_o, sd_cas_n_o, sd_we_n_o}, {3{~e_cmd}});
      check({cur_req, " addr"}, sd_addr_o == e_addr, sd_addr_o, e_addr);
      check({cur_req, " done"}, cpu_done_o == e_done, cpu_done_o, e_done);
      check({cur_req, " err"}, mode_err_o == e_err, mode_err_o, e_err);
      if (!sd_ras_n_o) cmd_cycles++;
      if (cpu_done_o) done_cycles++;
    end
  end

  task automatic access(input logic [31:0] addr, input logic [1:0] size, input logic wr);
    @(negedge clk_i);
    cpu_req_i  = 1'b1;
    cpu_addr_i = addr;
    cpu_size_i = size;
    cpu_wr_i   = wr;
    @(negedge clk_i);
    cpu_req_i  = 1'b0;
    cpu_addr_i = 32'h0;
  endtask

  task automatic settle();
    for (int i = 0; i < 30 && m_ph != 0; i++) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    cur_req = "R1";
    check("R1 reset lines", sd_cs_n_o == 2'b11 && sd_ras_n_o && sd_addr_o == 0 && !cpu_done_o,
          {sd_cs_n_o, sd_ras_n_o, cpu_done_o}, 4'b1110);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    begin : r2_blk
      int c0, d0;
      cur_req = "R2"; c0 = cmd_cycles; d0 = done_cycles;
      access(32'hFFF8_4030, 2'b01, 1'b1);
      settle();
      check("R2 one cmd clock", cmd_cycles - c0 == 1, cmd_cycles - c0, 1);
      check("R6 one done clock", done_cycles - d0 == 1, done_cycles - d0, 1);
    end

    begin : r3_blk
      int c0;
      cur_req = "R3"; c0 = cmd_cycles;
      access(32'hFFF8_5220, 2'b01, 1'b1);
      settle();
      check("R3 area1 cmd", cmd_cycles - c0 == 1, cmd_cycles - c0, 1);
      access(32'hFFF8_5020, 2'b01, 1'b1);
      settle();
    end

    cur_req = "R4_R9";
    access(32'hFFF8_4FFE, 2'b01, 1'b1);
    settle();
    access(32'hFFF8_5002, 2'b01, 1'b1);
    settle();

    begin : r5_blk
      int c0;
      cur_req = "R5"; c0 = cmd_cycles;
      sd_rdy_i = 1'b0;
      access(32'hFFF8_4230, 2'b01, 1'b1);
      repeat (5) @(negedge clk_i);
      check("R5 no cmd while busy", cmd_cycles == c0, cmd_cycles - c0, 0);
      sd_rdy_i = 1'b1;
      settle();
      check("R5 cmd after ready", cmd_cycles - c0 == 1, cmd_cycles - c0, 1);
    end

    begin : r7_blk
      int c0, d0;
      cur_req = "R7"; c0 = cmd_cycles; d0 = done_cycles;
      access(32'hFFF8_4020, 2'b00, 1'b1);
      settle();
      access(32'hFFF8_5030, 2'b10, 1'b1);
      settle();
      access(32'hFFF8_4020, 2'b01, 1'b0);
      settle();
      check("R7 no cmd", cmd_cycles == c0, cmd_cycles - c0, 0);
      check("R7 three dones", done_cycles - d0 == 3, done_cycles - d0, 3);
    end

    begin : r8_blk
      int c0, d0;
      cur_req = "R8"; c0 = cmd_cycles; d0 = done_cycles;
      access(32'hFFF8_6020, 2'b01, 1'b1);
      access(32'hFFF8_3020, 2'b01, 1'b1);
      access(32'h0000_4020, 2'b01, 1'b1);
      repeat (8) @(negedge clk_i);
      check("R8 silent cmd", cmd_cycles == c0, cmd_cycles - c0, 0);
      check("R8 silent done", done_cycles == d0, done_cycles - d0, 0);
    end

    begin : r10_blk
      int c0;
      cur_req = "R10"; c0 = cmd_cycles;
      access(32'hFFF8_4020, 2'b01, 1'b1);
      access(32'hFFF8_5030, 2'b01, 1'b1);
      access(32'hFFF8_5230, 2'b01, 1'b1);
      settle();
      check("R10 only first issued", cmd_cycles - c0 == 1, cmd_cycles - c0, 1);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule